// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable, behavioural synchronous SRAM. Reads and writes flow back to back on a shared data path without idle cycles: the lag of write data behind its command equals the lag of read data behind its command. A static mode input selects between two latencies. In pipelined mode, read data appears two edges after the address and write data is sampled two edges after the write command. In flow-through mode, both lags are one edge. Address, controls and byte enables are captured on the rising clock edge. The output enable and the burst-order select act without the clock.

An access either loads a new address or continues a burst. A burst steps a two-bit counter through four addresses in linear or interleaved order and repeats the operation type of the load. A clock-enable input freezes the whole core for wait states. A sleep request stops the core after a short delay while keeping the memory contents. After wake-up, writes are refused for a short recovery window. The bidirectional data bus is split into an input word, an output word and an output-drive flag. A read that hits a write whose data is still in flight receives that write's data.

Top module: `sram_zt_core`

## Requirements
- R1: A load access (`burst_cont`=0) is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 all hold. With any one of them inactive, the access is a deselect and `rdata_oe` stays 0 for its data slot. A continue (`burst_cont`=1) that follows a deselect is also a deselect.
- R2: In flow-through mode (`flow_mode`=1), a read captured at edge k drives `rdata_oe`=1 and the addressed word on `rdata` right after edge k.
- R3: In pipelined mode (`flow_mode`=0), a read captured at edge k presents its data right after edge k+1.
- R4: A write captured at edge k takes its data from `wdata` at edge k+2 in pipelined mode and at edge k+1 in flow-through mode.
- R5: `bw_n` bit b (active low) enables byte b, which is bits [9b+8:9b] of the word. A write with `bw_n` all ones changes nothing.
- R6: When `burst_ilv`=0, the n-th continue after a load of address A uses address bits [1:0] = (A[1:0]+n) mod 4, with the upper bits unchanged, and wraps after four addresses.
- R7: When `burst_ilv`=1, the n-th continue uses address bits [1:0] = A[1:0] XOR (n mod 4).
- R8: While `cke_n`=1, no state changes. A read already on the outputs in pipelined mode stays driven with the same data.
- R9: `rdata_oe` is 0 in the data slot of every write and deselect. `oe_n`=1 forces `rdata_oe` to 0 at once, without waiting for a clock edge.
- R10: `sleep_req` held high stops the core after two edges. While stopped, `rdata_oe` is 0, all access inputs are ignored, and the memory contents are kept.
- R11: The core resumes two edges after `sleep_req` falls. For the next two accesses it drops writes, while reads and deselects proceed normally.
- R12: In pipelined mode, a read that follows a write to the same address returns the newly written bytes, even before that write has reached the array.
- R13: While `rst_n`=0, `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | 1 selects flow-through, 0 selects pipelined (static) |
| cke_n | input | 1 | Active-low clock enable; high inserts a wait state |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| burst_cont | input | 1 | 1 continues the burst, 0 loads a new address |
| we_n | input | 1 | 0 writes, 1 reads (on a load) |
| bw_n | input | NBYTES | Active-low byte write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | NBYTES*BYTE_W | Write data, sampled at the late-write edge |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Sleep request, active high |
| rdata | output | NBYTES*BYTE_W | Read data |
| rdata_oe | output | 1 | High when the core drives `rdata` |

## Verification
The bench keeps the default parameters: two 9-bit bytes and a 64-word array. These are wide enough to show per-byte masking and a partial-word forward, and small enough to run full bursts at both an aligned and an unaligned start. It runs the same scripted traffic in both modes, resetting between them. It drives read-write-read sequences with no idle slot, so the two-edge late write and the forwarding path both come into play. Stalls and the sleep window are placed so that a read is already on the outputs or a write falls inside recovery.

// File: rtl/sram_zt_pkg.sv
package sram_zt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;
endpackage

// File: rtl/sram_zt_burst.sv
// Two-bit burst address generator: loads a base address, then steps
// the low two bits in linear or interleaved order on each continue.
module sram_zt_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d, cnt_inc, low;

  always_comb begin
    cnt_inc = cnt_q + 2'd1;
    low     = ilv ? (base_q[1:0] ^ cnt_inc) : (base_q[1:0] + cnt_inc);
    addr_out = load ? addr_in : {base_q[ADDR_W-1:2], low};
    base_d = base_q;
    cnt_d  = cnt_q;
    if (step_en) begin
      if (load) begin
        base_d = addr_in;
        cnt_d  = 2'd0;
      end else begin
        cnt_d  = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_zt_sleep.sv
// Sleep sequencer: a two-stage delay on the request, then a recovery
// window after wake-up during which writes are refused.
module sram_zt_sleep #(
  parameter int REC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep,
  output logic recovering
);
  localparam int RW = $clog2(REC_CYC + 1);

  logic          req1_q, req2_q;
  logic [RW-1:0] rec_q, rec_d;

  always_comb begin
    rec_d = rec_q;
    if (req2_q)                rec_d = RW'(REC_CYC);
    else if (rec_q != '0)      rec_d = rec_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req1_q <= 1'b0;
      req2_q <= 1'b0;
      rec_q  <= '0;
    end else begin
      req1_q <= sleep_req;
      req2_q <= req1_q;
      rec_q  <= rec_d;
    end
  end

  assign asleep     = req2_q;
  assign recovering = ~req2_q & (rec_q != '0);
endmodule

// File: rtl/sram_zt_array.sv
// Storage with per-byte write and a read port that overlays in-flight
// late-write bytes when asked to.
module sram_zt_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     fwd_en,
  input  logic [NBYTES-1:0]        fwd_be,
  input  logic [NBYTES*BYTE_W-1:0] fwd_data,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NBYTES * BYTE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] raw;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && wr_be[b])
        mem_q[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
    end
  end

  assign raw = mem_q[rd_addr];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign rd_data[g*BYTE_W +: BYTE_W] = (fwd_en && fwd_be[g]) ?
        fwd_data[g*BYTE_W +: BYTE_W] : raw[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sram_zt_core.sv
module sram_zt_core
  import sram_zt_pkg::*;
#(
  parameter  int ADDR_W = 6,
  parameter  int NBYTES = 2,
  parameter  int BYTE_W = 9,
  localparam int WORD_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              cke_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              burst_cont,
  input  logic              we_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic              sleep_req,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              asleep, recovering, core_en, selected;
  logic [ADDR_W-1:0] acc_addr;
  zt_op_e            acc_op;
  zt_op_e            last_q, last_d, s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [NBYTES-1:0] s1_be_q, s1_be_d, s2_be_q, s2_be_d;
  logic [WORD_W-1:0] dout_q, dout_d, rd_word;
  logic              wr_en, fwd_en, drive;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_be;

  sram_zt_sleep #(.REC_CYC(2)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .asleep(asleep), .recovering(recovering)
  );

  assign core_en  = ~cke_n & ~asleep;
  assign selected = ~sel1_n & sel2 & ~sel3_n;

  sram_zt_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .step_en(core_en), .load(~burst_cont),
    .ilv(burst_ilv), .addr_in(addr), .addr_out(acc_addr)
  );

  // Access decode: load picks the type from the selects and we_n,
  // continue repeats the previous type; recovery turns writes into idle.
  always_comb begin
    if (!burst_cont) acc_op = selected ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
    else             acc_op = last_q;
    if (recovering && acc_op == OP_WRITE) acc_op = OP_IDLE;
  end

  // Next state, all gated by the core clock enable.
  always_comb begin
    last_d    = last_q;
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_be_d   = s1_be_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    s2_be_d   = s2_be_q;
    dout_d    = dout_q;
    if (core_en) begin
      last_d    = acc_op;
      s1_op_d   = acc_op;
      s1_addr_d = acc_addr;
      s1_be_d   = ~bw_n;
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_be_d   = s1_be_q;
      dout_d    = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= OP_IDLE;
      s1_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s1_be_q   <= '0;
      s2_op_q   <= OP_IDLE;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
      dout_q    <= '0;
    end else begin
      last_q    <= last_d;
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_be_q   <= s1_be_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_be_q   <= s2_be_d;
      dout_q    <= dout_d;
    end
  end

  // Late write: commit from stage 1 (single late) or stage 2 (double late).
  always_comb begin
    if (flow_mode) begin
      wr_en   = core_en & (s1_op_q == OP_WRITE);
      wr_addr = s1_addr_q;
      wr_be   = s1_be_q;
    end else begin
      wr_en   = core_en & (s2_op_q == OP_WRITE);
      wr_addr = s2_addr_q;
      wr_be   = s2_be_q;
    end
  end

  assign fwd_en = ~flow_mode & (s2_op_q == OP_WRITE) & (s2_addr_q == s1_addr_q);

  sram_zt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wdata),
    .rd_addr(s1_addr_q), .fwd_en(fwd_en), .fwd_be(s2_be_q), .fwd_data(wdata),
    .rd_data(rd_word)
  );

  assign drive    = flow_mode ? (s1_op_q == OP_READ) : (s2_op_q == OP_READ);
  assign rdata_oe = drive & ~oe_n & ~asleep;
  assign rdata    = flow_mode ? rd_word : dout_q;
endmodule

// File: rtl/sram_zt_chk.sv
module sram_zt_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flow_mode,
  input logic              cke_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              burst_cont,
  input logic              we_n,
  input logic              oe_n,
  input logic              sleep_req,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              core_en,
  input logic              asleep
);
  logic [1:0] live_q;
  logic       sel_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_q <= 2'd0;
    else if (live_q != 2'd2) live_q <= live_q + 2'd1;
  end

  assign sel_all = ~sel1_n & sel2 & ~sel3_n;

  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && core_en && !burst_cont && !sel_all) |=> !rdata_oe);

  a_r2_flow_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && core_en && !burst_cont && sel_all && we_n)
      |=> (rdata_oe || oe_n || asleep));

  a_r3_pipe_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && core_en && !burst_cont && sel_all && we_n) ##1 core_en
      |=> (rdata_oe || oe_n || asleep));

  a_r9_flow_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && core_en && !burst_cont && sel_all && !we_n) |=> !rdata_oe);

  a_r9_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);

  a_r10_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !rdata_oe);

  a_r10_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == 2'd2 && $past(sleep_req, 2) && $past(sleep_req)) |-> asleep);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !asleep && !sleep_req)
      |=> (asleep || (oe_n != $past(oe_n)) || ($stable(rdata_oe) && $stable(rdata))));
endmodule

bind sram_zt_core sram_zt_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
  .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .burst_cont(burst_cont),
  .we_n(we_n), .oe_n(oe_n), .sleep_req(sleep_req), .rdata(rdata),
  .rdata_oe(rdata_oe), .core_en(core_en), .asleep(asleep)
);

// File: tb/test_sram_zt_core.sv
module test_sram_zt_core;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int W  = NB * BW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, flow_mode, cke_n, sel1_n, sel2, sel3_n, burst_cont, we_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata, rdata;
  logic          burst_ilv, oe_n, sleep_req, rdata_oe;

  sram_zt_core #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) i_sram_zt_core (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .burst_cont(burst_cont),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata), .burst_ilv(burst_ilv),
    .oe_n(oe_n), .sleep_req(sleep_req), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {
    int         due;
    bit         oe;
    logic [W-1:0] d;
    string      req;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] shadow [64];
  logic [W-1:0] sched [3];
  int cyc = 0, n_chk = 0, n_err = 0, lat = 2;
  int b_base = 0, b_cnt = 0, b_op = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic dcheck(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares each expected item in the cycle it falls due.
  always @(posedge clk) begin
    exp_t e;
    cyc++;
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      dcheck({e.req, " drive"}, W'(rdata_oe), W'(e.oe));
      if (e.oe) dcheck({e.req, " data"}, rdata, e.d);
    end
  end

  // kind: 0 deselect (sel2 low), 1 read, 2 write, 3 continue,
  //       4 read with sel1_n high, 5 write with sel3_n high
  // blk:  0 normal, 1 ignored by a sleeping core, 2 write dropped in recovery
  task automatic issue(input int kind, input int a, input logic [NB-1:0] bwn,
                       input logic [W-1:0] d, input int blk, input string req);
    int ea, op, low;
    exp_t e;
    wdata    = sched[0];
    sched[0] = sched[1];
    sched[1] = sched[2];
    sched[2] = '0;
    cke_n = 1'b0; addr = AW'(a); bw_n = bwn;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; burst_cont = 1'b0; we_n = 1'b1;
    case (kind)
      0: sel2 = 1'b0;
      2: we_n = 1'b0;
      3: burst_cont = 1'b1;
      4: sel1_n = 1'b1;
      5: begin sel3_n = 1'b1; we_n = 1'b0; end
      default: ;
    endcase
    if (blk != 1) begin
      if (kind == 3) begin
        b_cnt = (b_cnt + 1) % 4;
        low = burst_ilv ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
        ea = (b_base / 4) * 4 + low;
        op = b_op;
      end else begin
        b_base = a; b_cnt = 0; ea = a;
        op = (kind == 1) ? 1 : (kind == 2) ? 2 : 0;
      end
      if (blk == 2 && op == 2) op = 0;
      b_op = op;
      e.due = cyc + lat; e.req = req; e.d = '0; e.oe = 1'b0;
      if (op == 1) begin
        e.oe = 1'b1; e.d = shadow[ea];
      end else if (op == 2) begin
        for (int b = 0; b < NB; b++)
          if (!bwn[b]) shadow[ea][b*BW +: BW] = d[b*BW +: BW];
        sched[lat-1] = d;
      end
      sb.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic stall();
    cke_n = 1'b1;
    foreach (sb[i]) sb[i].due++;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit fm);
    rst_n = 1'b0; flow_mode = fm; lat = fm ? 1 : 2;
    cke_n = 1'b0; oe_n = 1'b0; sleep_req = 1'b0; burst_ilv = 1'b0;
    sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1; burst_cont = 1'b0; we_n = 1'b1;
    bw_n = '1; addr = '0; wdata = '0;
    for (int i = 0; i < 3; i++) sched[i] = '0;
    b_op = 0;
    repeat (3) @(negedge clk);
    dcheck("R13 reset drive", W'(rdata_oe), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // ---------------- pipelined mode ----------------
    do_reset(1'b0);
    issue(2, 4, 2'b00, 18'h12345, 0, "R4");
    issue(2, 5, 2'b00, 18'h0ABCD, 0, "R4");
    issue(1, 4, 2'b11, '0, 0, "R3");
    issue(1, 5, 2'b11, '0, 0, "R3");
    issue(2, 4, 2'b10, 18'h3FFFF, 0, "R5");
    issue(1, 4, 2'b11, '0, 0, "R12");
    issue(2, 5, 2'b11, 18'h00000, 0, "R5");
    issue(1, 5, 2'b11, '0, 0, "R5");
    issue(0, 6, 2'b11, '0, 0, "R1");
    issue(4, 4, 2'b11, '0, 0, "R1");
    issue(5, 4, 2'b00, 18'h00777, 0, "R1");
    issue(1, 4, 2'b11, '0, 0, "R1");
    // linear burst write from an aligned start, then reads from an unaligned start
    burst_ilv = 1'b0;
    issue(2, 8, 2'b00, 18'h00101, 0, "R6");
    issue(3, 0, 2'b00, 18'h00202, 0, "R6");
    issue(3, 0, 2'b00, 18'h00303, 0, "R6");
    issue(3, 0, 2'b00, 18'h00404, 0, "R6");
    issue(1, 10, 2'b11, '0, 0, "R6");
    for (int i = 0; i < 4; i++) issue(3, 0, 2'b11, '0, 0, "R6");
    burst_ilv = 1'b1;
    issue(1, 9, 2'b11, '0, 0, "R7");
    for (int i = 0; i < 3; i++) issue(3, 0, 2'b11, '0, 0, "R7");
    issue(0, 0, 2'b11, '0, 0, "R1");
    issue(3, 0, 2'b11, '0, 0, "R1");
    // stall with a read on the outputs
    issue(1, 4, 2'b11, '0, 0, "R8");
    issue(0, 0, 2'b11, '0, 0, "R8");
    stall();
    dcheck("R8 stall drive", W'(rdata_oe), W'(1));
    dcheck("R8 stall data", rdata, shadow[4]);
    stall();
    dcheck("R8 stall data", rdata, shadow[4]);
    oe_n = 1'b1; #1;
    dcheck("R9 oe_n off", W'(rdata_oe), W'(0));
    oe_n = 1'b0; #1;
    dcheck("R9 oe_n back", W'(rdata_oe), W'(1));
    for (int i = 0; i < 3; i++) issue(0, 0, 2'b11, '0, 0, "R1");

    // ---------------- flow-through mode ----------------
    do_reset(1'b1);
    issue(2, 20, 2'b00, 18'h2AAAA, 0, "R4");
    issue(1, 20, 2'b11, '0, 0, "R2");
    issue(2, 21, 2'b00, 18'h15555, 0, "R4");
    issue(2, 21, 2'b01, 18'h3FE00, 0, "R5");
    issue(1, 21, 2'b11, '0, 0, "R5");
    issue(2, 20, 2'b11, 18'h00000, 0, "R5");
    issue(1, 20, 2'b11, '0, 0, "R5");
    burst_ilv = 1'b0;
    issue(2, 32, 2'b00, 18'h00011, 0, "R6");
    issue(3, 0, 2'b00, 18'h00022, 0, "R6");
    issue(3, 0, 2'b00, 18'h00033, 0, "R6");
    issue(3, 0, 2'b00, 18'h00044, 0, "R6");
    burst_ilv = 1'b1;
    issue(1, 34, 2'b11, '0, 0, "R7");
    for (int i = 0; i < 3; i++) issue(3, 0, 2'b11, '0, 0, "R7");
    burst_ilv = 1'b0;
    issue(1, 33, 2'b11, '0, 0, "R6");
    for (int i = 0; i < 4; i++) issue(3, 0, 2'b11, '0, 0, "R6");
    issue(4, 20, 2'b11, '0, 0, "R1");
    issue(0, 0, 2'b11, '0, 0, "R1");
    // sleep entry, ignored inputs, wake-up recovery
    sleep_req = 1'b1;
    issue(1, 20, 2'b11, '0, 0, "R10");
    issue(1, 21, 2'b11, '0, 1, "R10");
    dcheck("R10 asleep drive", W'(rdata_oe), W'(0));
    for (int i = 0; i < 3; i++) issue(2, 20, 2'b00, 18'h3FFFF, 1, "R10");
    dcheck("R10 asleep drive", W'(rdata_oe), W'(0));
    sleep_req = 1'b0;
    issue(2, 20, 2'b00, 18'h3FFFF, 1, "R10");
    issue(2, 20, 2'b00, 18'h3FFFF, 1, "R10");
    issue(2, 20, 2'b00, 18'h00000, 2, "R11");
    issue(1, 20, 2'b11, '0, 0, "R11");
    issue(2, 20, 2'b00, 18'h01234, 0, "R11");
    issue(1, 20, 2'b11, '0, 0, "R11");
    for (int i = 0; i < 3; i++) issue(0, 0, 2'b11, '0, 0, "R1");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule